// File: doc/BRIEF.md
# Serial Audio Input Port

This block takes stereo PCM audio from a three-wire serial link (bit clock, left/right clock, serial data) and hands complete left and right sample words to a downstream encoder in the master clock (`clk_i`) domain. It runs as a slave, where both serial clocks come from outside and may be unrelated to `clk_i`, or as a master, where it divides `clk_i` to drive both clocks itself.

Six static controls set the format: master/slave, a two-bit word length code, left or right justification, a one-bit data delay after the left/right change, the bit clock edge that samples data, and which left/right clock level means left. Together they cover left-justified, the delayed "I2S" layout, and right-justified 16- and 24-bit streams. All three serial lines are oversampled by `clk_i`, so every decision is made on master clock edges and a finished left/right pair is flagged by a single-cycle strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: During and after reset, until a frame completes, `valid_o` is 0, `left_o` and `right_o` are 0, and `bck_o` and `lrck_o` are 0.
- R2: With `rjust_i`=0 and `delay_i`=0, the word's MSB is the bit taken on the first active bit clock edge at which the effective left/right level differs from the previous active edge; the next N-1 active edges carry the remaining bits MSB first, and later slots of the phase are ignored.
- R3: With `delay_i`=1 and `rjust_i`=0, the MSB is taken on the second active edge of the phase instead of the first.
- R4: With `rjust_i`=1, the word is the last N bits taken before the next left/right change; all earlier slots of the phase are ignored.
- R5: `res_i` selects N: 00 gives 24 bits, 01 gives 20 bits, 10 and 11 give 16 bits; the word is placed MSB-aligned in the 24-bit output with the unused low bits at 0.
- R6: `bck_fall_i`=0 takes data and left/right level on rising bit clock edges; `bck_fall_i`=1 takes them on falling edges.
- R7: `lr_inv_i`=0 means a low left/right clock marks the left phase; `lr_inv_i`=1 means a high level marks the left phase.
- R8: With `master_i`=1, `ratio_i` 00, 01, 10/11 select 128, 256, 512 `clk_i` cycles per frame; `bck_o` has a period of ratio/64 cycles, `lrck_o` a period of ratio cycles (low half first), and every `lrck_o` change coincides with a falling `bck_o` edge.
- R9: `valid_o` pulses for exactly one `clk_i` cycle per frame, once the right phase closes, and only if the left phase before it was captured in full after a left/right change seen since reset; `left_o` and `right_o` change only with that pulse.
- R10: In slave mode the bit clock may be asynchronous to `clk_i`, may stop between phases, and the two phases may differ in length (up to 63 slots, at least enough for the word); each bit clock level must last at least 3 `clk_i` periods.
- R11: With `master_i`=0, `bck_o` and `lrck_o` stay at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master (oversampling) clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1: generate serial clocks, 0: take them from pins |
| ratio_i | input | 2 | Master clock to frame rate ratio code |
| res_i | input | 2 | Word length code |
| rjust_i | input | 1 | 1: right-justified, 0: left-justified |
| delay_i | input | 1 | One-slot data delay after left/right change |
| bck_fall_i | input | 1 | 1: sample on falling bit clock edge |
| lr_inv_i | input | 1 | 1: high left/right level marks left |
| bck_i | input | 1 | Slave bit clock |
| lrck_i | input | 1 | Slave left/right clock |
| sdata_i | input | 1 | Serial data |
| bck_o | output | 1 | Generated bit clock (master mode) |
| lrck_o | output | 1 | Generated left/right clock (master mode) |
| left_o | output | 24 | Left sample, MSB aligned |
| right_o | output | 24 | Right sample, MSB aligned |
| valid_o | output | 1 | One-cycle strobe for a new pair |

## Verification
Frames carry all-ones, alternating and random words, with filler ones in every slot outside the word, so a capture window that is one slot early, late or too wide changes the result; right-justified runs also distinguish "last N bits" from "first N bits". Each format is run under its own control set (no delay, one-slot delay, 16/20/24-bit, inverted sampling edge, inverted left/right level), and a run with unequal phase lengths and long bit clock pauses separates edge counting from time counting. Master runs at all three ratios measure the generated clock periods and feed data against those clocks, and a leading lone right phase shows that no pair is issued before a full left phase.

// File: rtl/sai_pkg.sv
package sai_pkg;

  typedef enum logic [1:0] {
    RATIO_128  = 2'b00,
    RATIO_256  = 2'b01,
    RATIO_512  = 2'b10,
    RATIO_512B = 2'b11
  } ratio_e;

  // divider tap offset for the bit clock
  function automatic logic [1:0] ratio_shift(input logic [1:0] code);
    if (code == RATIO_128) return 2'd0;
    if (code == RATIO_256) return 2'd1;
    return 2'd2;
  endfunction

  function automatic int unsigned word_bits(input logic [1:0] code, input int unsigned full);
    unique case (code)
      2'b00:   return full;
      2'b01:   return full - 4;
      default: return full - 8;
    endcase
  endfunction

endpackage

// File: rtl/sai_clkgen.sv
module sai_clkgen import sai_pkg::*; #(
  parameter int unsigned SLOTS_PER_FRAME = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       master_i,
  input  logic [1:0] ratio_i,
  output logic       bck_o,
  output logic       lrck_o
);
  localparam int unsigned LR_OFS = $clog2(SLOTS_PER_FRAME);
  localparam int unsigned DIV_W  = LR_OFS + 3;
  localparam int unsigned IDX_W  = $clog2(DIV_W);

  logic [DIV_W-1:0] div_q;
  logic [IDX_W-1:0] bck_idx, lr_idx;
  logic             bck_q, lr_q;

  assign bck_idx = IDX_W'(ratio_shift(ratio_i));
  assign lr_idx  = IDX_W'(LR_OFS) + bck_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      bck_q <= 1'b0;
      lr_q  <= 1'b0;
    end else if (master_i) begin
      div_q <= div_q + 1'b1;
      bck_q <= div_q[bck_idx];
      lr_q  <= div_q[lr_idx];
    end else begin
      div_q <= '0;
      bck_q <= 1'b0;
      lr_q  <= 1'b0;
    end
  end

  assign bck_o  = bck_q;
  assign lrck_o = lr_q;

  // R8
  lr_on_bck_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i && !$stable(lr_q) |-> $fell(bck_q));

  // R11
  slave_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(master_i) |-> !bck_q && !lr_q);

endmodule

// File: rtl/sai_edge.sv
module sai_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bck_i,
  input  logic lrck_i,
  input  logic sd_i,
  input  logic fall_i,
  input  logic lr_inv_i,
  output logic act_o,
  output logic lr_o,
  output logic sd_o
);
  logic [SYNC_STAGES-1:0] bck_s, lr_s, sd_s;
  logic                   bck_d;

  // data and lrck share the bit clock's delay so they stay aligned to its edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bck_s <= '0;
      lr_s  <= '0;
      sd_s  <= '0;
      bck_d <= 1'b0;
    end else begin
      bck_s <= {bck_s[SYNC_STAGES-2:0], bck_i};
      lr_s  <= {lr_s[SYNC_STAGES-2:0], lrck_i};
      sd_s  <= {sd_s[SYNC_STAGES-2:0], sd_i};
      bck_d <= bck_s[SYNC_STAGES-1];
    end
  end

  assign act_o = fall_i ? (bck_d & ~bck_s[SYNC_STAGES-1])
                        : (~bck_d & bck_s[SYNC_STAGES-1]);
  assign lr_o  = lr_s[SYNC_STAGES-1] ^ lr_inv_i;
  assign sd_o  = sd_s[SYNC_STAGES-1];

endmodule

// File: rtl/sai_deser.sv
module sai_deser import sai_pkg::*; #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              lr_i,
  input  logic              sd_i,
  input  logic              delay_i,
  input  logic              rjust_i,
  input  logic [1:0]        res_i,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              valid_o
);
  logic [CNT_W-1:0]  n_bits, first_slot, end_slot, pad, idx_q;
  logic [DATA_W-1:0] keep_mask, word, sh_q, hold_q, left_q, right_q;
  logic              phase_q, seen_q, left_ok_q, valid_q, take;

  assign n_bits     = CNT_W'(word_bits(res_i, DATA_W));
  assign first_slot = CNT_W'(delay_i);
  assign end_slot   = first_slot + n_bits;
  assign pad        = CNT_W'(DATA_W) - n_bits;
  assign keep_mask  = ~({DATA_W{1'b1}} << n_bits);
  assign word       = (sh_q & keep_mask) << pad;
  // right-justified keeps shifting; the mask leaves the last N bits
  assign take       = rjust_i || (idx_q >= first_slot && idx_q < end_slot);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= '0;
      sh_q      <= '0;
      hold_q    <= '0;
      left_q    <= '0;
      right_q   <= '0;
      phase_q   <= 1'b0;
      seen_q    <= 1'b0;
      left_ok_q <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (act_i) begin
        if (lr_i != phase_q) begin
          phase_q <= lr_i;
          seen_q  <= 1'b1;
          idx_q   <= CNT_W'(1);
          sh_q    <= (rjust_i || !delay_i) ? DATA_W'(sd_i) : '0;
          if (seen_q) begin
            if (!phase_q) begin
              hold_q    <= word;
              left_ok_q <= 1'b1;
            end else if (left_ok_q) begin
              left_q    <= hold_q;
              right_q   <= word;
              valid_q   <= 1'b1;
              left_ok_q <= 1'b0;
            end
          end
        end else begin
          if (take) sh_q <= {sh_q[DATA_W-2:0], sd_i};
          if (idx_q != {CNT_W{1'b1}}) idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;

  // R9
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  // R5
  low_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && res_i[1] |-> (left_q[7:0] == 8'h00) && (right_q[7:0] == 8'h00));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx import sai_pkg::*; #(
  parameter int unsigned DATA_W          = 24,
  parameter int unsigned CNT_W           = 6,
  parameter int unsigned SLOTS_PER_FRAME = 64,
  parameter int unsigned SYNC_STAGES     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic [1:0]        ratio_i,
  input  logic [1:0]        res_i,
  input  logic              rjust_i,
  input  logic              delay_i,
  input  logic              bck_fall_i,
  input  logic              lr_inv_i,
  input  logic              bck_i,
  input  logic              lrck_i,
  input  logic              sdata_i,
  output logic              bck_o,
  output logic              lrck_o,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              valid_o
);
  logic bck_m, lrck_m, bck_sel, lrck_sel, act, lr_eff, sd_eff;

  sai_clkgen #(.SLOTS_PER_FRAME(SLOTS_PER_FRAME)) u_clkgen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .master_i(master_i),
    .ratio_i (ratio_i),
    .bck_o   (bck_m),
    .lrck_o  (lrck_m)
  );

  assign bck_sel  = master_i ? bck_m  : bck_i;
  assign lrck_sel = master_i ? lrck_m : lrck_i;

  sai_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bck_i   (bck_sel),
    .lrck_i  (lrck_sel),
    .sd_i    (sdata_i),
    .fall_i  (bck_fall_i),
    .lr_inv_i(lr_inv_i),
    .act_o   (act),
    .lr_o    (lr_eff),
    .sd_o    (sd_eff)
  );

  sai_deser #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_deser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act),
    .lr_i   (lr_eff),
    .sd_i   (sd_eff),
    .delay_i(delay_i),
    .rjust_i(rjust_i),
    .res_i  (res_i),
    .left_o (left_o),
    .right_o(right_o),
    .valid_o(valid_o)
  );

  assign bck_o  = bck_m;
  assign lrck_o = lrck_m;

endmodule

// File: tb/serial_audio_rx_tb_top.sv
module serial_audio_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BCK   = 33;

  logic clk = 1'b0, rst_n = 1'b0;
  logic master = 1'b0, rjust = 1'b0, delay = 1'b0, fall = 1'b0, lr_inv = 1'b0;
  logic [1:0] ratio = 2'b00, res = 2'b00;
  logic bck_i = 1'b0, lrck_i = 1'b0, sdata_i = 1'b0;
  logic bck_o, lrck_o, valid_o;
  logic [23:0] left_o, right_o;

  int checks = 0, errors = 0;
  bit mon_en = 1'b1, valid_prev = 1'b0;
  string cur_req = "R2";
  logic [23:0] exp_l[$], exp_r[$];
  logic [23:0] last_l = '0, last_r = '0, mon_l, mon_r;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_audio_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master), .ratio_i(ratio), .res_i(res),
    .rjust_i(rjust), .delay_i(delay), .bck_fall_i(fall), .lr_inv_i(lr_inv),
    .bck_i(bck_i), .lrck_i(lrck_i), .sdata_i(sdata_i), .bck_o(bck_o), .lrck_o(lrck_o),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference: queue of sent pairs, compared on every clock
  always @(negedge clk) begin
    if (!rst_n) begin
      valid_prev = 1'b0; last_l = '0; last_r = '0;
    end else begin
      if (valid_o) begin
        if (mon_en) begin
          check(!valid_prev, "R9", "valid wider than one cycle", 32'(valid_prev), 0);
          if (exp_l.size() == 0) check(1'b0, "R9", "valid without a sent frame", 1, 0);
          else begin
            mon_l = exp_l.pop_front(); mon_r = exp_r.pop_front();
            check(left_o == mon_l, cur_req, "left word", 32'(left_o), 32'(mon_l));
            check(right_o == mon_r, cur_req, "right word", 32'(right_o), 32'(mon_r));
          end
        end
        last_l = left_o; last_r = right_o;
      end else if (left_o != last_l || right_o != last_r) begin
        check(1'b0, "R9", "outputs moved without valid", 32'(left_o), 32'(last_l));
      end
      valid_prev = valid_o;
    end
  end

  function automatic int bits_for(input logic [1:0] code);
    return (code == 2'b00) ? 24 : (code == 2'b01) ? 20 : 16;
  endfunction

  function automatic bit slot_val(input logic [23:0] w, input int n, input int slot, input int slots);
    int pos;
    if (rjust) begin
      pos = slots - n;
      if (slot < pos) return 1'b1;
      return w[n-1-(slot-pos)];
    end
    if (slot < int'(delay) || slot >= int'(delay) + n) return 1'b1;
    return w[n-1-(slot-int'(delay))];
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; bck_i = fall; lrck_i = lr_inv; sdata_i = 1'b0;
    exp_l.delete(); exp_r.delete();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic slave_slot(input bit right, input bit d);
    lrck_i = right ^ lr_inv; sdata_i = d;
    #HALF_BCK; bck_i = ~fall;
    #HALF_BCK; bck_i = fall;
  endtask

  task automatic slave_run(input string req, input int nfr, input int lslots,
                           input int rslots, input int gap);
    int n;
    logic [23:0] mask;
    n = bits_for(res);
    mask = (n == 24) ? 24'hFFFFFF : 24'((1 << n) - 1);
    cur_req = req;
    for (int k = 0; k < rslots; k++) slave_slot(1'b1, 1'b0); // lone right phase: no pair (R9)
    for (int f = 0; f < nfr; f++) begin
      logic [23:0] wl, wr;
      if (f == 0) begin wl = mask; wr = 24'h1; end
      else if (f == 1) begin wl = 24'hA5A5A5 & mask; wr = 24'h5A5A5A & mask; end
      else begin wl = 24'($urandom) & mask; wr = 24'($urandom) & mask; end
      exp_l.push_back(wl << (24 - n)); exp_r.push_back(wr << (24 - n));
      for (int k = 0; k < lslots; k++) slave_slot(1'b0, slot_val(wl, n, k, lslots));
      if (gap > 0) #(gap);
      for (int k = 0; k < rslots; k++) slave_slot(1'b1, slot_val(wr, n, k, rslots));
      if (gap > 0) #(gap);
    end
    for (int k = 0; k < 4; k++) slave_slot(1'b0, 1'b0);
    repeat (20) @(negedge clk);
    check(exp_l.size() == 0, req, "pairs still outstanding", 32'(exp_l.size()), 0);
  endtask

  task automatic master_run(input logic [1:0] rc, input int per);
    realtime t0, t1;
    logic [23:0] wl, wr;
    master = 1'b1; ratio = rc; res = 2'b00; rjust = 1'b0; delay = 1'b0; fall = 1'b0; lr_inv = 1'b0;
    mon_en = 1'b0;
    do_reset();
    cur_req = "R8";
    @(posedge bck_o); t0 = $realtime; @(posedge bck_o); t1 = $realtime;
    check(int'((t1 - t0) / CLK_PERIOD) == per / 64, "R8", "bck_o period",
          32'(int'((t1 - t0) / CLK_PERIOD)), 32'(per / 64));
    @(posedge lrck_o); t0 = $realtime; @(posedge lrck_o); t1 = $realtime;
    check(int'((t1 - t0) / CLK_PERIOD) == per, "R8", "lrck_o period",
          32'(int'((t1 - t0) / CLK_PERIOD)), 32'(per));
    for (int f = 0; f < 2; f++) begin
      wl = 24'($urandom); wr = 24'($urandom);
      exp_l.push_back(wl); exp_r.push_back(wr);
      @(negedge lrck_o); #1; sdata_i = slot_val(wl, 24, 0, 32);
      for (int k = 1; k < 32; k++) begin
        @(negedge bck_o); #1; sdata_i = slot_val(wl, 24, k, 32);
        if (f == 0 && k == 4) mon_en = 1'b1;
      end
      for (int k = 0; k < 32; k++) begin
        @(negedge bck_o); #1; sdata_i = slot_val(wr, 24, k, 32);
      end
    end
    repeat (per) @(negedge clk);
    check(exp_l.size() == 0, "R8", "master pairs outstanding", 32'(exp_l.size()), 0);
    master = 1'b0;
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(1'b0, "watchdog", "run did not complete", 0, 1);
    finish_sim();
  end

  initial begin
    do_reset();
    // R1 reset state
    check(valid_o == 1'b0, "R1", "valid_o after reset", 32'(valid_o), 0);
    check(left_o == '0, "R1", "left_o after reset", 32'(left_o), 0);
    check(right_o == '0, "R1", "right_o after reset", 32'(right_o), 0);
    check(bck_o == 1'b0 && lrck_o == 1'b0, "R1", "clock outputs after reset", 32'({bck_o, lrck_o}), 0);

    // R2 left-justified 24-bit
    res = 2'b00; rjust = 1'b0; delay = 1'b0; do_reset();
    slave_run("R2", 4, 32, 32, 0);
    // R11 slave mode keeps generated clocks low
    check(bck_o == 1'b0 && lrck_o == 1'b0, "R11", "clock outputs in slave mode", 32'({bck_o, lrck_o}), 0);

    // R3 one-slot delay
    delay = 1'b1; do_reset();
    slave_run("R3", 3, 32, 32, 0);

    // R4 right-justified 24 and 16 bit
    delay = 1'b0; rjust = 1'b1; do_reset();
    slave_run("R4", 3, 32, 32, 0);
    res = 2'b10; do_reset();
    slave_run("R4", 3, 32, 32, 0);

    // R5 word length codes 20 and 16 (code 11)
    rjust = 1'b0; res = 2'b01; do_reset();
    slave_run("R5", 3, 32, 32, 0);
    res = 2'b11; delay = 1'b1; do_reset();
    slave_run("R5", 3, 32, 32, 0);

    // R6 falling-edge sampling
    res = 2'b00; fall = 1'b1; do_reset();
    slave_run("R6", 3, 32, 32, 0);

    // R7 inverted left/right level
    fall = 1'b0; delay = 1'b0; lr_inv = 1'b1; do_reset();
    slave_run("R7", 3, 32, 32, 0);

    // R10 unequal phases and paused bit clock
    lr_inv = 1'b0; do_reset();
    slave_run("R10", 3, 26, 40, 400);
    rjust = 1'b1; res = 2'b10; do_reset();
    slave_run("R10", 2, 18, 63, 250);

    // R8 master mode at each ratio
    master_run(2'b00, 128);
    master_run(2'b01, 256);
    master_run(2'b10, 512);

    finish_sim();
  end

endmodule